// File: doc/BRIEF.md
# Real-Time Clock Counter with Compare Alarm

This block keeps time as a 64-bit value: a 32-bit seconds word above a 32-bit sub-second word. The sub-second word steps once for each cycle of the `tick_en` input and rolls over into the seconds word at a parameterised modulus. A 64-bit compare value raises a sticky alarm flag on the tick that brings the time onto it. A seconds compare word of all ones means that no alarm is armed.

Software reaches seven word registers through a plain write strobe and a combinational read port. Every write is a delayed commit. The block takes the write, holds a busy flag for `WR_CYCLES` cycles, and then applies the value. A write it cannot take is dropped and flagged as an error. The block comes out of reset marked non-valid. Time stays frozen until software clears that mark and has loaded the seconds word at least once. One interrupt line ORs together the enabled status conditions.

Top module: `rtc_alarm_core`

## Requirements
- R1: Register offsets: 0 seconds, 1 sub-second, 2 alarm seconds, 3 alarm sub-second, 4 control, 5 status, 6 interrupt enable. Offset 7 is not mapped: it reads 0, and a write committed to it changes no register and sets the error flag (status bit 7).
- R2: After reset, status reads 0x202 (bit 9 and bit 1 set). Both time words, the alarm sub-second word, control and interrupt enable read 0. Alarm seconds reads 0xFFFFFFFF, and `irq` is low.
- R3: A write seen while not busy is accepted. Status bit 10 (busy) is then set for exactly `WR_CYCLES` cycles, and the value lands at the end of that window. Status bit 9 (ready for next write) always reads as the inverse of bit 10.
- R4: A write strobe seen while busy is discarded: no register takes its value, and status bit 7 is set.
- R5: A commit to a mapped offset sets status bit 8 (complete). The exception is a status write carrying a 1 in bit 8, which leaves bit 8 clear.
- R6: Status bits 8, 7 and 4 are cleared by committing a status write with a 1 in that position. Bit 1 (non-valid) clears only when bits 1 and 0 are both written as 1. Bit 0 (security violation) always reads 0.
- R7: Time advances only when four things hold: control bit 3 is set, the seconds word has been written, bit 1 is clear, and `tick_en` is high. Each advance adds one to the sub-second word. When that word is at or above `FRAC_MOD`-1, it returns to 0 and the seconds word adds one.
- R8: After reset, time does not advance until a seconds write has committed, even with everything else enabled. Sub-second writes are still stored during that time.
- R9: While status bit 1 is set, time does not advance.
- R10: Status bit 4 (alarm) is set on the advance whose new 64-bit time equals {alarm seconds, alarm sub-second}. This never happens while alarm seconds is 0xFFFFFFFF.
- R11: `irq` is high when any of status bits 9, 8, 7 or 4 is set together with the interrupt-enable bit at the same position. Other interrupt-enable bits are not stored.
- R12: A committing write to a time word takes priority over a tick on the same cycle. The read-back value is then exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One advance of the sub-second word per high cycle |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 3 | Word offset for both write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt, OR of enabled status conditions |

## Verification
The hardest cases to reach are the collisions between a pending commit and something else arriving on the same edge. One is a second strobe landing while the first is still in flight. The other is a tick landing on the very cycle a time word commits. The stimulus forces the first by holding `wr_en` high for two consecutive cycles. It forces the second by holding `tick_en` high across a whole write, so that the edge of the commit must also carry a tick. The sub-second wrap has to happen inside that window, so the bench uses a small modulus. Random tick streams from a fixed seed then check the carry arithmetic against a bench model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    RA_SEC      = 3'd0,
    RA_FRAC     = 3'd1,
    RA_ALM_SEC  = 3'd2,
    RA_ALM_FRAC = 3'd3,
    RA_CTRL     = 3'd4,
    RA_STAT     = 3'd5,
    RA_IEN      = 3'd6
  } reg_addr_e;

  localparam int B_BUSY  = 10;
  localparam int B_NEXT  = 9;
  localparam int B_DONE  = 8;
  localparam int B_ERR   = 7;
  localparam int B_ALM   = 4;
  localparam int B_INVAL = 1;
  localparam int B_TAMP  = 0;
  localparam int B_RUN   = 3;

  localparam logic [31:0] IRQ_SRC_MASK =
    (32'd1 << B_NEXT) | (32'd1 << B_DONE) | (32'd1 << B_ERR) | (32'd1 << B_ALM);
endpackage

// File: rtl/rtc_wr_engine.sv
module rtc_wr_engine #(
  parameter int AW        = 3,
  parameter int DW        = 32,
  parameter int WR_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          commit,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data,
  output logic          discard
);
  localparam int CW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (wr_en) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(WR_CYCLES - 1);
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  assign busy    = busy_q;
  assign commit  = busy_q && (cnt_q == '0);
  assign cm_addr = addr_q;
  assign cm_data = data_q;
  assign discard = wr_en && busy_q;
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int W        = 32,
  parameter int FRAC_MOD = 32768
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic         ld_sec,
  input  logic         ld_frac,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] sec,
  output logic [W-1:0] frac,
  output logic [W-1:0] nxt_sec,
  output logic [W-1:0] nxt_frac
);
  localparam logic [W-1:0] FRAC_TOP = W'(FRAC_MOD - 1);

  logic [W-1:0] sec_q, frac_q;

  always_comb begin
    if (frac_q >= FRAC_TOP) begin
      nxt_frac = '0;
      nxt_sec  = sec_q + 1'b1;
    end else begin
      nxt_frac = frac_q + 1'b1;
      nxt_sec  = sec_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      frac_q <= '0;
    end else begin
      if (ld_sec)       sec_q <= ld_val;
      else if (advance) sec_q <= nxt_sec;
      if (ld_frac)      frac_q <= ld_val;
      else if (advance) frac_q <= nxt_frac;
    end
  end

  assign sec  = sec_q;
  assign frac = frac_q;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] nxt_sec,
  input  logic [W-1:0] nxt_frac,
  input  logic [W-1:0] alm_sec,
  input  logic [W-1:0] alm_frac,
  output logic         hit
);
  logic armed;
  assign armed = (alm_sec != {W{1'b1}});
  assign hit   = armed && ({nxt_sec, nxt_frac} == {alm_sec, alm_frac});
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
  import rtc_pkg::*;
#(
  parameter int WR_CYCLES = 4,
  parameter int FRAC_MOD  = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int DW = 32;
  localparam int AW = 3;

  logic          busy, commit, discard;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;

  rtc_wr_engine #(.AW(AW), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr), .wr_data(wdata),
    .busy(busy), .commit(commit), .cm_addr(cm_addr), .cm_data(cm_data),
    .discard(discard)
  );

  logic c_sec, c_frac, c_asec, c_afrac, c_ctrl, c_stat, c_ien, c_mapped;
  assign c_sec    = commit && (cm_addr == RA_SEC);
  assign c_frac   = commit && (cm_addr == RA_FRAC);
  assign c_asec   = commit && (cm_addr == RA_ALM_SEC);
  assign c_afrac  = commit && (cm_addr == RA_ALM_FRAC);
  assign c_ctrl   = commit && (cm_addr == RA_CTRL);
  assign c_stat   = commit && (cm_addr == RA_STAT);
  assign c_ien    = commit && (cm_addr == RA_IEN);
  assign c_mapped = c_sec | c_frac | c_asec | c_afrac | c_ctrl | c_stat | c_ien;

  logic [DW-1:0] alm_sec_q, alm_frac_q, ctrl_q, ier_q;
  logic          wcf_q, wef_q, caf_q, nvf_q, sec_seen_q;

  logic          advance, hit;
  logic [DW-1:0] sec, frac, nxt_sec, nxt_frac;

  assign advance = tick_en && ctrl_q[B_RUN] && sec_seen_q && !nvf_q && !c_sec && !c_frac;

  rtc_timebase #(.W(DW), .FRAC_MOD(FRAC_MOD)) u_tb (
    .clk(clk), .rst_n(rst_n), .advance(advance), .ld_sec(c_sec), .ld_frac(c_frac),
    .ld_val(cm_data), .sec(sec), .frac(frac), .nxt_sec(nxt_sec), .nxt_frac(nxt_frac)
  );

  rtc_alarm_match #(.W(DW)) u_alm (
    .nxt_sec(nxt_sec), .nxt_frac(nxt_frac), .alm_sec(alm_sec_q), .alm_frac(alm_frac_q),
    .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_sec_q  <= '1;
      alm_frac_q <= '0;
      ctrl_q     <= '0;
      ier_q      <= '0;
      sec_seen_q <= 1'b0;
    end else begin
      if (c_asec)  alm_sec_q  <= cm_data;
      if (c_afrac) alm_frac_q <= cm_data;
      if (c_ctrl)  ctrl_q     <= cm_data;
      if (c_ien)   ier_q      <= cm_data & IRQ_SRC_MASK;
      if (c_sec)   sec_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcf_q <= 1'b0;
      wef_q <= 1'b0;
      caf_q <= 1'b0;
      nvf_q <= 1'b1;
    end else begin
      if (c_stat && cm_data[B_INVAL] && cm_data[B_TAMP]) nvf_q <= 1'b0;
      if (c_stat && cm_data[B_ALM]) caf_q <= 1'b0;
      else if (advance && hit)      caf_q <= 1'b1;
      if (discard || (commit && !c_mapped)) wef_q <= 1'b1;
      else if (c_stat && cm_data[B_ERR])    wef_q <= 1'b0;
      if (c_mapped) wcf_q <= !(c_stat && cm_data[B_DONE]);
    end
  end

  logic [DW-1:0] stat;
  always_comb begin
    stat          = '0;
    stat[B_BUSY]  = busy;
    stat[B_NEXT]  = !busy;
    stat[B_DONE]  = wcf_q;
    stat[B_ERR]   = wef_q;
    stat[B_ALM]   = caf_q;
    stat[B_INVAL] = nvf_q;
    stat[B_TAMP]  = 1'b0;
  end

  always_comb begin
    case (addr)
      RA_SEC:      rdata = sec;
      RA_FRAC:     rdata = frac;
      RA_ALM_SEC:  rdata = alm_sec_q;
      RA_ALM_FRAC: rdata = alm_frac_q;
      RA_CTRL:     rdata = ctrl_q;
      RA_STAT:     rdata = stat;
      RA_IEN:      rdata = ier_q;
      default:     rdata = '0;
    endcase
  end

  assign irq = |(stat & ier_q & IRQ_SRC_MASK);
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int WR_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        busy,
  input logic        commit,
  input logic        wef,
  input logic        nvf,
  input logic        run_en,
  input logic        sec_seen,
  input logic [31:0] sec,
  input logic [31:0] frac,
  input logic [31:0] ier,
  input logic        irq
);
  localparam int RW = $clog2(WR_CYCLES + 2) + 1;
  logic [RW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> busy); // R3
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= RW'(WR_CYCLES)); // R3
  AST_DISCARD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wef); // R4
  AST_TIME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((!sec_seen || nvf || !run_en) && !commit) |=> $stable({sec, frac})); // R8
  AST_INVALID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (nvf && !commit) |=> nvf); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 32'd0) |-> !irq); // R11
endmodule

bind rtc_alarm_core rtc_alarm_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .commit(commit),
  .wef(wef_q), .nvf(nvf_q), .run_en(ctrl_q[3]), .sec_seen(sec_seen_q),
  .sec(sec), .frac(frac), .ier(ier_q), .irq(irq)
);

// File: tb/test_rtc_alarm_core.sv
`timescale 1ns/1ps
module test_rtc_alarm_core;
  localparam int WRC = 4;
  localparam int MOD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_sec, m_frac;
  bit m_run;

  always #2.5 clk = ~clk;

  rtc_alarm_core #(.WR_CYCLES(WRC), .FRAC_MOD(MOD)) i_rtc_alarm_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #0.5;
    v = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (WRC) @(negedge clk);
  endtask

  function automatic void step_model();
    if (m_frac >= 32'(MOD - 1)) begin
      m_frac = 0;
      m_sec  = m_sec + 1;
    end else begin
      m_frac = m_frac + 1;
    end
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      if (m_run) step_model();
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_sec = 0; m_frac = 0; m_run = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    @(negedge clk);
    // R2 reset state
    chk_reg("R2 status", 3'd5, 32'h202);
    chk_reg("R2 sec", 3'd0, 0);
    chk_reg("R2 frac", 3'd1, 0);
    chk_reg("R2 alarm sec", 3'd2, 32'hFFFF_FFFF);
    chk_reg("R2 alarm frac", 3'd3, 0);
    chk_reg("R2 ctrl", 3'd4, 0);
    chk_reg("R2 ien", 3'd6, 0);
    chk("R2 irq", {31'd0, irq}, 0);

    wr(3'd4, 32'h8);
    wr(3'd0, 32'd100);
    m_sec = 100;
    chk_reg("R5 complete after commit", 3'd5, 32'h302);
    ticks(3);
    chk_reg("R9 sec frozen while invalid", 3'd0, 100);
    chk_reg("R9 frac frozen while invalid", 3'd1, 0);
    wr(3'd5, 32'h2);
    chk_reg("R6 invalid kept without bit0", 3'd5, 32'h302);
    wr(3'd5, 32'h3);
    chk_reg("R6 invalid cleared", 3'd5, 32'h300);
    m_run = 1;
    ticks(10);
    chk_reg("R7 carry sec", 3'd0, m_sec);
    chk_reg("R7 carry frac", 3'd1, m_frac);
    chk("R7 model", m_sec, 101);

    // R3 busy window
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd4; wdata = 32'h8;
    @(negedge clk);
    wr_en = 1'b0;
    chk_reg("R3 busy set, next clear", 3'd5, 32'h500);
    repeat (WRC - 1) @(negedge clk);
    chk_reg("R3 still busy last cycle", 3'd5, 32'h500);
    @(negedge clk);
    chk_reg("R3 busy released", 3'd5, 32'h300);

    // R4 discard
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = 32'd555;
    @(negedge clk);
    addr = 3'd3; wdata = 32'd7;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (WRC) @(negedge clk);
    m_sec = 555;
    chk_reg("R4 discarded value absent", 3'd3, 0);
    chk_reg("R4 first write landed", 3'd0, 555);
    chk_reg("R4 error flag", 3'd5, 32'h380);
    wr(3'd5, 32'h80);
    chk_reg("R6 error cleared", 3'd5, 32'h300);
    wr(3'd5, 32'h100);
    chk_reg("R6 R5 complete cleared", 3'd5, 32'h200);
    wr(3'd7, 32'hDEAD_BEEF);
    chk_reg("R1 unmapped write error", 3'd5, 32'h280);
    chk_reg("R1 unmapped reads zero", 3'd7, 0);
    wr(3'd5, 32'h80);

    // R10 alarm
    wr(3'd1, 0);
    m_frac = 0;
    wr(3'd2, 32'd555);
    wr(3'd3, 32'd3);
    wr(3'd6, 32'h10);
    chk("R11 irq masked", {31'd0, irq}, 0);
    ticks(2);
    chk_reg("R10 no alarm early", 3'd5, 32'h300);
    ticks(1);
    chk_reg("R10 alarm on match", 3'd5, 32'h310);
    chk("R11 irq on alarm", {31'd0, irq}, 1);
    wr(3'd5, 32'h10);
    chk_reg("R6 alarm cleared", 3'd5, 32'h300);
    chk("R11 irq dropped", {31'd0, irq}, 0);

    // R10 unset alarm
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'd4);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 0);
    m_sec = 32'hFFFF_FFFF; m_frac = 0;
    ticks(4);
    chk_reg("R10 unset frac reached", 3'd1, 4);
    chk_reg("R10 unset no alarm", 3'd5, 32'h300);

    // R11 next-write interrupt
    wr(3'd6, 32'h200 | 32'hF000_0000);
    chk_reg("R11 unused enable bits dropped", 3'd6, 32'h200);
    chk("R11 irq ready", {31'd0, irq}, 1);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd6; wdata = 32'h0;
    @(negedge clk);
    wr_en = 1'b0;
    #0.5;
    chk("R11 irq low while busy", {31'd0, irq}, 0);
    repeat (WRC) @(negedge clk);

    // R12 commit beats tick
    tick_en = 1'b1;
    wr(3'd1, 32'd6);
    tick_en = 1'b0;
    chk_reg("R12 frac exact", 3'd1, 6);
    chk_reg("R12 sec wrapped by earlier ticks", 3'd0, 0);
    m_sec = 0; m_frac = 6;

    // R7 random
    m_sec = $urandom;
    m_frac = $urandom_range(0, MOD - 1);
    wr(3'd0, m_sec);
    wr(3'd1, m_frac);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] vs, vf;
      @(negedge clk);
      rd(3'd0, vs);
      rd(3'd1, vf);
      if (i % 20 == 0 || vs !== m_sec || vf !== m_frac) begin
        chk("R7 random sec", vs, m_sec);
        chk("R7 random frac", vf, m_frac);
      end
      tick_en = ($urandom_range(0, 1) == 1);
      if (tick_en) step_model();
    end
    @(negedge clk);
    tick_en = 1'b0;

    // R8 frozen until seconds written
    do_reset();
    wr(3'd5, 32'h3);
    wr(3'd4, 32'h8);
    ticks(5);
    chk_reg("R8 sec frozen", 3'd0, 0);
    chk_reg("R8 frac frozen", 3'd1, 0);
    wr(3'd1, 32'd5);
    ticks(3);
    chk_reg("R8 frac stored, held", 3'd1, 5);
    wr(3'd0, 32'd7);
    m_sec = 7; m_frac = 5; m_run = 1;
    ticks(4);
    chk_reg("R8 sec runs after write", 3'd0, 8);
    chk_reg("R8 frac runs after write", 3'd1, 1);

    summary();
    $finish;
  end
endmodule